// File: doc/BRIEF.md
# Mode-Aware Memory Permission Checker

This block decides, in a single combinational pass, whether one memory access may proceed. It takes a vector of per-entry address hits computed elsewhere, the configuration byte of every protection entry, the privilege of the requester (machine, or the less privileged supervisor/user level), the kind of access (read, write or execute), and two global policy bits: a lockdown bit and a machine allowlist bit. It produces a single allow flag. A deny is the caller's cue to raise an access fault.

Among the entries whose hit bit is set and whose address mode is not off, the lowest-numbered one decides. With lockdown clear, the classic rules apply: a locked entry binds every privilege, and an unlocked entry binds only the less privileged level. With lockdown set, the lock bit instead picks which side an entry serves. The read-clear/write-set encodings and the all-ones encoding become regions shared by both sides. Machine execution then needs an explicit rule.

Top module: `mem_perm_check`

## Requirements
- R1: Each configuration byte holds read permission in bit 0, write in bit 1, execute in bit 2, address mode in bits 4:3 (00 = off) and lock in bit 7. An entry whose address mode is 00 never matches. The access code is 00 read, 01 write, 10 execute, and code 11 is always denied.
- R2: When several effective entries match, only the lowest-numbered one decides the result.
- R3: With lockdown clear, a matching locked entry applies its read/write/execute bits to every privilege. A matching unlocked entry allows any machine access and applies its bits to supervisor/user accesses.
- R4: When no entry matches, a supervisor/user access is denied. A machine read or write is allowed unless the allowlist bit is set. A machine execute is allowed only when both the lockdown and allowlist bits are clear.
- R5: With lockdown set, a matching entry with lock=0 that is not a shared encoding applies its bits to supervisor/user accesses and denies machine accesses.
- R6: With lockdown set, a matching entry with lock=1 that is not a shared encoding applies its bits to machine accesses and denies supervisor/user accesses.
- R7: With lockdown set, lock=0, read=0, write=1 is shared data. Machine may read and write. Supervisor/user may read, and may write only when execute=1. Nobody may execute.
- R8: With lockdown set, lock=1, read=0, write=1 is shared code. Both sides may execute, machine may read only when execute=1, and nobody may write.
- R9: With lockdown set, lock/read/write/execute all 1 is shared read-only. Both sides may read, and nothing else is allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| entry_hit | input | N_ENTRIES | Address-range hit per entry, bit i for entry i |
| entry_cfg | input | 8*N_ENTRIES | Configuration bytes, entry i in bits 8i+7:8i |
| priv_machine | input | 1 | 1 = machine privilege, 0 = supervisor/user |
| access_kind | input | 2 | 00 read, 01 write, 10 execute, 11 invalid |
| lockdown | input | 1 | Machine lockdown policy bit |
| allowlist | input | 1 | Machine allowlist policy bit (deny on no match) |
| allow | output | 1 | 1 = access permitted |

## Verification
Priority selection and the lockdown decode act in the same evaluation. The bench provokes this by setting hit bits on two entries at once, a low-numbered one whose lockdown encoding denies and a higher one that would allow. It then swaps the two configurations, so the result shows that only the first effective hit was decoded. A second overlap is the no-match default under both policy bits together, where the execute restriction and the allowlist rule must combine. A behavioural model, driven per cycle with directed cases and then pseudo-random ones, judges every cycle at the falling clock edge.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_BAD = 2'b11
    } acc_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        logic [1:0] amode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    function automatic logic perm_bit(input cfg_t c, input acc_e a);
        case (a)
            ACC_RD:  return c.r;
            ACC_WR:  return c.w;
            ACC_EX:  return c.x;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic classic_rule(input cfg_t c, input logic m, input acc_e a);
        if (a == ACC_BAD) return 1'b0;
        if (!c.lock && m) return 1'b1;
        return perm_bit(c, a);
    endfunction

    function automatic logic is_shared_rw(input cfg_t c);
        return !c.r && c.w;
    endfunction

    function automatic logic is_shared_ro(input cfg_t c);
        return c.lock && c.r && c.w && c.x;
    endfunction

    function automatic logic lockdown_rule(input cfg_t c, input logic m, input acc_e a);
        if (a == ACC_BAD) return 1'b0;
        if (is_shared_ro(c)) return (a == ACC_RD);
        if (is_shared_rw(c) && !c.lock) begin
            case (a)
                ACC_RD:  return 1'b1;
                ACC_WR:  return m | c.x;
                default: return 1'b0;
            endcase
        end
        if (is_shared_rw(c) && c.lock) begin
            case (a)
                ACC_EX:  return 1'b1;
                ACC_RD:  return m & c.x;
                default: return 1'b0;
            endcase
        end
        if (c.lock == m) return perm_bit(c, a);
        return 1'b0;
    endfunction

    function automatic logic miss_rule(input logic m, input acc_e a,
                                       input logic lkd, input logic awl);
        if (a == ACC_BAD) return 1'b0;
        if (!m) return 1'b0;
        if (awl) return 1'b0;
        if (lkd && a == ACC_EX) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/mpc_priority_select.sv
module mpc_priority_select #(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0] req,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx,
    output logic [N_ENTRIES-1:0] grant
);
    always_comb begin
        hit   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit   = 1'b1;
                idx   = IDX_W'(i);
                grant = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        p_single_grant_r2: assert ($onehot0(grant))
            else $error("more than one entry granted");
        p_hit_tracks_req_r2: assert (hit == (|req))
            else $error("hit disagrees with request vector");
        p_grant_is_requested_r2: assert ((grant & ~req) == '0)
            else $error("grant on a non-requesting entry");
    end

    for (genvar g = 1; g < N_ENTRIES; g++) begin : g_lower_chk
        always_comb begin
            p_no_lower_req_r2: assert (!(grant[g] && (|req[g-1:0])))
                else $error("grant skipped a lower-numbered entry");
        end
    end
endmodule

// File: rtl/mpc_rule_eval.sv
module mpc_rule_eval
    import mpc_pkg::*;
(
    input  cfg_t cfg,
    input  logic priv_m,
    input  acc_e acc,
    input  logic lkd,
    output logic rule_ok
);
    logic classic_ok;
    logic lockdown_ok;

    always_comb begin
        classic_ok  = classic_rule(cfg, priv_m, acc);
        lockdown_ok = lockdown_rule(cfg, priv_m, acc);
        rule_ok     = lkd ? lockdown_ok : classic_ok;
    end

    always_comb begin
        p_su_denied_mside_r6: assert (!(lkd && cfg.lock && !priv_m && cfg.r && !(cfg.w && cfg.x)) || !rule_ok)
            else $error("supervisor/user passed a machine-only rule");
        p_m_denied_suside_r5: assert (!(lkd && !cfg.lock && priv_m && !(!cfg.r && cfg.w)) || !rule_ok)
            else $error("machine passed a supervisor/user-only rule");
        p_shared_ro_only_r9: assert (!(lkd && cfg.lock && cfg.r && cfg.w && cfg.x && acc != ACC_RD) || !rule_ok)
            else $error("shared read-only region allowed non-read");
        p_shared_data_noexec_r7: assert (!(lkd && !cfg.lock && !cfg.r && cfg.w && acc == ACC_EX) || !rule_ok)
            else $error("shared data region allowed execute");
        p_shared_code_nowrite_r8: assert (!(lkd && cfg.lock && !cfg.r && cfg.w && acc == ACC_WR) || !rule_ok)
            else $error("shared code region allowed write");
        p_bad_code_r1: assert (acc != ACC_BAD || !rule_ok)
            else $error("invalid access code allowed");
    end
endmodule

// File: rtl/mem_perm_check.sv
module mem_perm_check
    import mpc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0]       entry_hit,
    input  logic [CFG_W*N_ENTRIES-1:0] entry_cfg,
    input  logic                       priv_machine,
    input  logic [1:0]                 access_kind,
    input  logic                       lockdown,
    input  logic                       allowlist,
    output logic                       allow
);
    cfg_t                 cfg_arr [N_ENTRIES];
    logic [N_ENTRIES-1:0] eff_hit;
    logic                 any_hit;
    logic [IDX_W-1:0]     win_idx;
    logic [N_ENTRIES-1:0] win_grant;
    cfg_t                 win_cfg;
    logic                 rule_ok;
    logic                 miss_ok;
    acc_e                 acc;

    assign acc = acc_e'(access_kind);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        assign cfg_arr[g] = cfg_t'(entry_cfg[g*CFG_W +: CFG_W]);
        assign eff_hit[g] = entry_hit[g] && (cfg_arr[g].amode != 2'b00);
    end

    mpc_priority_select #(.N_ENTRIES(N_ENTRIES)) u_sel (
        .req   (eff_hit),
        .hit   (any_hit),
        .idx   (win_idx),
        .grant (win_grant)
    );

    always_comb begin
        win_cfg = cfg_arr[0];
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (IDX_W'(i) == win_idx) win_cfg = cfg_arr[i];
        end
    end

    mpc_rule_eval u_eval (
        .cfg     (win_cfg),
        .priv_m  (priv_machine),
        .acc     (acc),
        .lkd     (lockdown),
        .rule_ok (rule_ok)
    );

    always_comb begin
        miss_ok = miss_rule(priv_machine, acc, lockdown, allowlist);
        allow   = any_hit ? rule_ok : miss_ok;
    end

    always_comb begin
        p_su_miss_denied_r4: assert (any_hit || priv_machine || !allow)
            else $error("supervisor/user allowed with no matching entry");
        p_allowlist_miss_r4: assert (any_hit || !allowlist || !allow)
            else $error("allowlist set yet unmatched access allowed");
        p_lockdown_exec_miss_r4: assert (any_hit || !lockdown || acc != ACC_EX || !allow)
            else $error("lockdown set yet unmatched execute allowed");
        p_off_never_wins_r1: assert (!any_hit || win_grant[win_idx])
            else $error("winning index not granted");
    end
endmodule

// File: tb/sim_mem_perm_check.sv
module sim_mem_perm_check;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic [N-1:0] hit;
    logic [8*N-1:0] cfg;
    logic         pm;
    logic [1:0]   acc;
    logic         mml;
    logic         mmwp;
    logic         allow;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    armed = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R4";
    bit    use_model_tag = 1'b0;
    int    cycles = 0;

    always #10 clk = ~clk;

    mem_perm_check #(.N_ENTRIES(N)) u0 (
        .entry_hit    (hit),
        .entry_cfg    (cfg),
        .priv_machine (pm),
        .access_kind  (acc),
        .lockdown     (mml),
        .allowlist    (mmwp),
        .allow        (allow)
    );

    function automatic logic [7:0] mk(input bit l, input bit r, input bit w, input bit x);
        return {l, 2'b00, 2'b11, x, w, r};
    endfunction

    // Behavioural reference built from the requirement text.
    function automatic bit model(input logic [8*N-1:0] c, input logic [N-1:0] h,
                                 input bit m, input int a, input bit lk, input bit wl,
                                 output string tag);
        int win = -1;
        bit l, r, w, x;
        for (int i = 0; i < N; i++) begin
            if (win < 0 && h[i] && c[8*i+3 +: 2] != 2'b00) win = i;
        end
        if (a == 3) begin tag = "R1"; return 0; end
        if (win < 0) begin
            tag = "R4";
            if (!m) return 0;
            if (wl) return 0;
            if (lk && a == 2) return 0;
            return 1;
        end
        l = c[8*win+7]; r = c[8*win]; w = c[8*win+1]; x = c[8*win+2];
        if (!lk) begin
            tag = "R3";
            if (!l && m) return 1;
            return (a == 0) ? r : (a == 1) ? w : x;
        end
        case ({l, r, w, x})
            4'b0010: begin tag = "R7"; return (a == 0) || (a == 1 && m); end
            4'b0011: begin tag = "R7"; return (a == 0) || (a == 1); end
            4'b1010: begin tag = "R8"; return (a == 2); end
            4'b1011: begin tag = "R8"; return (a == 2) || (a == 0 && m); end
            4'b1111: begin tag = "R9"; return (a == 0); end
            default: begin
                if (l) begin
                    tag = "R6";
                    if (!m) return 0;
                end else begin
                    tag = "R5";
                    if (m) return 0;
                end
                return (a == 0) ? r : (a == 1) ? w : x;
            end
        endcase
    endfunction

    always @(negedge clk) begin
        if (armed && !done) begin
            string mt;
            bit exp_v;
            exp_v = model(cfg, hit, pm, int'(acc), mml, mmwp, mt);
            n_checks++;
            if (allow !== exp_v) begin
                n_errors++;
                $display("FAIL %s: allow=%b expected=%b (hit=%h cfg=%h m=%b acc=%0d lkd=%b awl=%b)",
                         use_model_tag ? mt : cur_tag, allow, exp_v, hit, cfg, pm, acc, mml, mmwp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog: cycles=%0d expected<=200000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic apply(input string tag, input logic [N-1:0] h, input logic [8*N-1:0] c,
                         input bit m, input logic [1:0] a, input bit lk, input bit wl);
        @(posedge clk);
        #1;
        cur_tag = tag; hit = h; cfg = c; pm = m; acc = a; mml = lk; mmwp = wl;
    endtask

    initial begin
        logic [8*N-1:0] c;
        hit = '0; cfg = '0; pm = 1'b0; acc = 2'b00; mml = 1'b0; mmwp = 1'b0;
        repeat (2) @(posedge clk);
        armed = 1'b1;
        // Reset-like idle state: nothing matches, supervisor/user read denied
        apply("R4", '0, '0, 0, 2'b00, 0, 0);

        // R1: entry 0 has mode off, entry 1 read-only; supervisor read sees entry 1
        c = '0; c[7:0] = 8'b0000_0111; c[15:8] = mk(0,1,0,0);
        apply("R1", 8'b0000_0011, c, 0, 2'b00, 0, 0);
        apply("R1", 8'b0000_0011, c, 0, 2'b01, 0, 0);
        // R1: invalid access code on a fully permissive entry
        c = '0; c[7:0] = mk(1,1,1,0) | 8'h04;
        apply("R1", 8'b0000_0001, c, 1, 2'b11, 0, 0);

        // R2: overlap, deny-all low entry wins under lockdown
        c = '0; c[23:16] = mk(0,0,0,0); c[47:40] = mk(0,1,1,1);
        apply("R2", 8'b0010_0100, c, 0, 2'b00, 1, 0);
        c = '0; c[23:16] = mk(0,1,1,1); c[47:40] = mk(0,0,0,0);
        apply("R2", 8'b0010_0100, c, 0, 2'b00, 1, 0);

        // R3: classic lock semantics
        c = '0; c[7:0] = mk(0,0,0,0);
        apply("R3", 8'b1, c, 1, 2'b01, 0, 0);
        apply("R3", 8'b1, c, 0, 2'b00, 0, 0);
        c = '0; c[7:0] = mk(1,1,0,0);
        apply("R3", 8'b1, c, 1, 2'b01, 0, 0);
        apply("R3", 8'b1, c, 1, 2'b00, 0, 0);

        // R4: defaults on no match
        apply("R4", '0, '0, 1, 2'b00, 0, 0);
        apply("R4", '0, '0, 1, 2'b10, 0, 0);
        apply("R4", '0, '0, 1, 2'b00, 0, 1);
        apply("R4", '0, '0, 1, 2'b10, 1, 0);
        apply("R4", '0, '0, 1, 2'b01, 1, 0);
        apply("R4", '0, '0, 1, 2'b10, 1, 1);

        // R5 and R6: side selection by lock under lockdown
        c = '0; c[7:0] = mk(0,1,1,1);
        apply("R5", 8'b1, c, 1, 2'b00, 1, 0);
        apply("R5", 8'b1, c, 0, 2'b01, 1, 0);
        c = '0; c[7:0] = mk(1,1,0,1);
        apply("R6", 8'b1, c, 1, 2'b10, 1, 0);
        apply("R6", 8'b1, c, 0, 2'b00, 1, 0);
        apply("R6", 8'b1, c, 1, 2'b01, 1, 0);

        // R7: shared data
        c = '0; c[7:0] = mk(0,0,1,0);
        apply("R7", 8'b1, c, 0, 2'b01, 1, 0);
        apply("R7", 8'b1, c, 0, 2'b00, 1, 0);
        apply("R7", 8'b1, c, 1, 2'b01, 1, 0);
        apply("R7", 8'b1, c, 1, 2'b10, 1, 0);
        c = '0; c[7:0] = mk(0,0,1,1);
        apply("R7", 8'b1, c, 0, 2'b01, 1, 0);
        apply("R7", 8'b1, c, 0, 2'b10, 1, 0);

        // R8: shared code
        c = '0; c[7:0] = mk(1,0,1,0);
        apply("R8", 8'b1, c, 1, 2'b00, 1, 0);
        apply("R8", 8'b1, c, 1, 2'b10, 1, 0);
        apply("R8", 8'b1, c, 0, 2'b10, 1, 0);
        c = '0; c[7:0] = mk(1,0,1,1);
        apply("R8", 8'b1, c, 1, 2'b00, 1, 0);
        apply("R8", 8'b1, c, 0, 2'b00, 1, 0);
        apply("R8", 8'b1, c, 1, 2'b01, 1, 0);

        // R9: shared read-only
        c = '0; c[7:0] = mk(1,1,1,1);
        apply("R9", 8'b1, c, 0, 2'b00, 1, 0);
        apply("R9", 8'b1, c, 1, 2'b00, 1, 0);
        apply("R9", 8'b1, c, 1, 2'b01, 1, 0);
        apply("R9", 8'b1, c, 0, 2'b10, 1, 0);

        // Pseudo-random sweep, tag chosen by the model's decision path
        use_model_tag = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            logic [8*N-1:0] rc;
            for (int e = 0; e < N; e++) rc[8*e +: 8] = 8'($urandom);
            apply("R2", 8'($urandom) & 8'($urandom), rc, 1'($urandom), 2'($urandom),
                  1'($urandom), ($urandom % 4) == 0);
        end

        @(posedge clk);
        @(negedge clk);
        armed = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule